// File: doc/BRIEF.md
# Serial EEPROM Protected Word-Write Sequencer

This block stores a single 16-bit word into a three-wire serial EEPROM. It is told what to store with a one-cycle start pulse carrying a 6-bit word address and the data word. It then runs the full guarded write with no further help. First it sends a command that unlocks writing. Next it sends the write command with its address and data. It then waits for the device to finish its internal programming, and last it sends a command that locks writing again. Between commands the device is dropped into standby.

The block drives chip select, the serial clock and the serial data line towards the device. It reads the device's serial data line back only to learn when programming is finished. The serial clock is derived from the system clock by a parameterised divider. A programmable poll limit stops a device that never becomes ready from hanging the sequence. In that case an error flag is raised and the lock command is still sent.

Top module: `mw_word_writer`

## Requirements
- R1: Out of reset, and while reset is held, chip select, serial clock, serial data out, busy, done and error are all low.
- R2: The first command of a sequence is 9 bits, sent MSB first: the unlock pattern 1,0,0,1,1 followed by four zero bits (value 9'h130).
- R3: Chip select stays low for at least one full serial clock period (2*CLK_DIV system clocks) between successive commands. The serial clock is low whenever chip select is low.
- R4: The second command is 25 bits, sent MSB first: 1,0,1, then the 6-bit address latched at start, then the 16-bit data latched at start. Address and data inputs are not used after the start cycle.
- R5: Serial data out changes only while the serial clock is low. Each high phase of the serial clock lasts CLK_DIV system clocks, and the device samples on the rising edge.
- R6: After the write command and a standby gap, chip select is raised with no clock pulses, and the device's data line is polled once per half serial period. Chip select drops within CLK_DIV+1 system clocks after the line is seen high.
- R7: If the line is not high within POLL_LIMIT polls, the error flag is set and the sequence goes on to the lock command. The flag is cleared when the next start is accepted.
- R8: The last command is 9 bits, 1,0,0,0,0 then four zero bits (value 9'h100). After it and a standby gap, done is high for exactly one cycle, and busy is already low in that cycle.
- R9: Start pulses while busy are ignored: the sequence produces exactly the four chip-select windows of the original request, and nothing runs afterwards.
- R10: Busy is high in the cycle after an accepted start and stays high until done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to write a word |
| addr_i | input | ADDR_W | Word address, sampled with start |
| data_i | input | DATA_W | Word to store, sampled with start |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Poll limit reached in last sequence |
| mw_cs_o | output | 1 | Chip select to the EEPROM |
| mw_clk_o | output | 1 | Serial clock to the EEPROM |
| mw_tx_o | output | 1 | Serial data to the EEPROM |
| mw_rx_i | input | 1 | Serial data from the EEPROM (ready flag) |

## Verification
The bench aims at the edges of the write: all-zero and all-one address and data words, a device that is ready before polling starts, and one that never becomes ready. If the shift order or the frame alignment were off, the bench would capture unlock, write or lock patterns that differ from the expected values. A sequencer that skipped standby, or that dropped select too early while polling, would show up as a short low gap or as a poll window that closes with the device still busy. A second start pulse in the middle of a sequence would, in a block that accepted it, change the latched address or add extra chip-select windows.

// File: rtl/mw_pkg.sv
package mw_pkg;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_SHIFT,
      PH_GAP,
      PH_POLL
   } phase_t;

   typedef enum logic [1:0] {
      ST_UNLOCK,
      ST_WRITE,
      ST_WAIT,
      ST_LOCK
   } step_t;

   localparam logic [4:0] OP_UNLOCK = 5'b10011;
   localparam logic [4:0] OP_LOCK   = 5'b10000;
   localparam logic [2:0] OP_WRITE  = 3'b101;

endpackage

// File: rtl/mw_tick_gen.sv
module mw_tick_gen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);

   generate
      if (DIV < 1) begin : g_bad_div
         $error("mw_tick_gen: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_every
         assign tick = en;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n || !en) begin
               cnt_q <= '0;
            end else if (cnt_q == CW'(DIV - 1)) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign tick = en && (cnt_q == CW'(DIV - 1));

         a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/mw_shift_reg.sv
module mw_shift_reg #(
   parameter int W = 25
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   output logic         msb
);

   generate
      if (W < 2) begin : g_bad_w
         $error("mw_shift_reg: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] sr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (load) begin
         sr_q <= load_val;
      end else if (shift) begin
         sr_q <= {sr_q[W-2:0], 1'b0};
      end
   end

   assign msb = sr_q[W-1];

endmodule

// File: rtl/mw_word_writer.sv
module mw_word_writer
   import mw_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int DATA_W     = 16,
   parameter int CLK_DIV    = 4,
   parameter int POLL_LIMIT = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic              mw_cs_o,
   output logic              mw_clk_o,
   output logic              mw_tx_o,
   input  logic              mw_rx_i
);

   localparam int CMD_W   = 3 + ADDR_W;
   localparam int FRAME_W = CMD_W + DATA_W;
   localparam int BIT_CW  = $clog2(FRAME_W + 1);
   localparam int POLL_CW = $clog2(POLL_LIMIT + 1);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("mw_word_writer: ADDR_W must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("mw_word_writer: DATA_W must be at least 1");
      end
      if (POLL_LIMIT < 1) begin : g_bad_poll
         $error("mw_word_writer: POLL_LIMIT must be at least 1");
      end
   endgenerate

   phase_t              phase_q;
   step_t               step_q;
   logic                cs_q, sck_q, gap_half_q, err_q, done_q;
   logic [BIT_CW-1:0]   bit_cnt_q;
   logic [POLL_CW-1:0]  poll_cnt_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   data_q;
   logic                tick;

   // frames, left aligned so the bits after a short command shift out as zero
   logic [FRAME_W-1:0]  unlock_frame, lock_frame, write_frame;
   assign unlock_frame = {OP_UNLOCK, {(ADDR_W - 2){1'b0}}, {DATA_W{1'b0}}};
   assign lock_frame   = {OP_LOCK,   {(ADDR_W - 2){1'b0}}, {DATA_W{1'b0}}};
   assign write_frame  = {OP_WRITE, addr_q, data_q};

   mw_tick_gen #(.DIV(CLK_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (phase_q != PH_IDLE),
      .tick (tick)
   );

   // shifter control
   logic               gap_end;
   logic               sh_load, sh_shift;
   logic [FRAME_W-1:0] sh_val;

   assign gap_end = (phase_q == PH_GAP) && tick && gap_half_q;

   always_comb begin
      sh_load  = 1'b0;
      sh_val   = '0;
      sh_shift = (phase_q == PH_SHIFT) && tick && sck_q;
      if (phase_q == PH_IDLE && start_i) begin
         sh_load = 1'b1;
         sh_val  = unlock_frame;
      end else if (gap_end && step_q == ST_UNLOCK) begin
         sh_load = 1'b1;
         sh_val  = write_frame;
      end else if (gap_end && step_q == ST_WAIT) begin
         sh_load = 1'b1;
         sh_val  = lock_frame;
      end
   end

   mw_shift_reg #(.W(FRAME_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (sh_load),
      .load_val(sh_val),
      .shift   (sh_shift),
      .msb     (mw_tx_o)
   );

   // sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         step_q     <= ST_UNLOCK;
         cs_q       <= 1'b0;
         sck_q      <= 1'b0;
         gap_half_q <= 1'b0;
         err_q      <= 1'b0;
         done_q     <= 1'b0;
         bit_cnt_q  <= '0;
         poll_cnt_q <= '0;
         addr_q     <= '0;
         data_q     <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (start_i) begin
                  addr_q    <= addr_i;
                  data_q    <= data_i;
                  err_q     <= 1'b0;
                  cs_q      <= 1'b1;
                  bit_cnt_q <= BIT_CW'(CMD_W);
                  step_q    <= ST_UNLOCK;
                  phase_q   <= PH_SHIFT;
               end
            end
            PH_SHIFT: begin
               if (tick) begin
                  if (!sck_q) begin
                     sck_q <= 1'b1;
                  end else begin
                     sck_q     <= 1'b0;
                     bit_cnt_q <= bit_cnt_q - 1'b1;
                     if (bit_cnt_q == BIT_CW'(1)) begin
                        cs_q       <= 1'b0;
                        gap_half_q <= 1'b0;
                        phase_q    <= PH_GAP;
                     end
                  end
               end
            end
            PH_GAP: begin
               if (tick) begin
                  if (!gap_half_q) begin
                     gap_half_q <= 1'b1;
                  end else begin
                     gap_half_q <= 1'b0;
                     unique case (step_q)
                        ST_UNLOCK: begin
                           step_q    <= ST_WRITE;
                           cs_q      <= 1'b1;
                           bit_cnt_q <= BIT_CW'(FRAME_W);
                           phase_q   <= PH_SHIFT;
                        end
                        ST_WRITE: begin
                           step_q     <= ST_WAIT;
                           cs_q       <= 1'b1;
                           poll_cnt_q <= '0;
                           phase_q    <= PH_POLL;
                        end
                        ST_WAIT: begin
                           step_q    <= ST_LOCK;
                           cs_q      <= 1'b1;
                           bit_cnt_q <= BIT_CW'(CMD_W);
                           phase_q   <= PH_SHIFT;
                        end
                        ST_LOCK: begin
                           phase_q <= PH_IDLE;
                           done_q  <= 1'b1;
                        end
                        default: phase_q <= PH_IDLE;
                     endcase
                  end
               end
            end
            PH_POLL: begin
               if (tick) begin
                  if (mw_rx_i) begin
                     cs_q       <= 1'b0;
                     gap_half_q <= 1'b0;
                     phase_q    <= PH_GAP;
                  end else if (poll_cnt_q == POLL_CW'(POLL_LIMIT - 1)) begin
                     err_q      <= 1'b1;
                     cs_q       <= 1'b0;
                     gap_half_q <= 1'b0;
                     phase_q    <= PH_GAP;
                  end else begin
                     poll_cnt_q <= poll_cnt_q + 1'b1;
                  end
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign busy_o   = (phase_q != PH_IDLE);
   assign done_o   = done_q;
   assign err_o    = err_q;
   assign mw_cs_o  = cs_q;
   assign mw_clk_o = sck_q;

   // R5: data to the device holds while the serial clock stays high
   a_r5_tx_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (mw_clk_o && $past(mw_clk_o)) |-> $stable(mw_tx_o));

   // R3: no clock pulses outside a chip-select window
   a_r3_clk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      !mw_cs_o |-> !mw_clk_o);

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   a_r10_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   a_r9_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mw_cs_o);

   a_r7_err_from_poll: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> $past(phase_q == PH_POLL));

endmodule

// File: tb/tb_mw_word_writer.sv
module tb_mw_word_writer;

   localparam int AW    = 6;
   localparam int DW    = 16;
   localparam int DIV   = 2;
   localparam int LIMIT = 40;
   localparam int FRM   = 3 + AW + DW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic [DW-1:0] data_i = '0;
   logic          busy_o, done_o, err_o, mw_cs_o, mw_clk_o, mw_tx_o;
   logic          rx = 1'b1;

   always #10 clk = ~clk;

   mw_word_writer #(.ADDR_W(AW), .DATA_W(DW), .CLK_DIV(DIV), .POLL_LIMIT(LIMIT)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .data_i(data_i),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
      .mw_cs_o(mw_cs_o), .mw_clk_o(mw_clk_o), .mw_tx_o(mw_tx_o), .mw_rx_i(rx)
   );

   int total = 0;
   int fails = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // device model, sampled away from the active edge
   int          cyc = 0, nb = 0, nfr = 0, gap = 0, min_gap = 0, hi_len = 0;
   int          prog = 0, delay_cfg = 0, rdy_cyc = 0, open_cyc = 0, poll_lat = 0;
   int          tx_bad = 0, hi_bad = 0;
   logic [31:0] fvv = '0;
   int          fb [0:7];
   logic [31:0] fv [0:7];
   bit          poll_rdy = 1'b0;
   logic        p_cs = 1'b0, p_sck = 1'b0, p_tx = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (mw_cs_o && !p_cs) begin
            if (nfr > 0 && gap < min_gap) min_gap = gap;
            nb = 0; fvv = '0; open_cyc = cyc;
         end
         if (mw_cs_o && mw_clk_o && !p_sck) begin
            fvv = {fvv[30:0], mw_tx_o};
            nb++;
         end
         if (mw_clk_o && p_sck && mw_tx_o != p_tx) tx_bad++;
         if (mw_clk_o) hi_len++;
         else if (p_sck) begin
            if (hi_len != DIV) hi_bad++;
            hi_len = 0;
         end
         if (!mw_cs_o && p_cs) begin
            if (nfr < 8) begin fb[nfr] = nb; fv[nfr] = fvv; end
            if (nb == 0) begin
               poll_rdy = rx;
               poll_lat = cyc - ((rdy_cyc > open_cyc) ? rdy_cyc : open_cyc);
            end
            if (nb == FRM && fvv[FRM-1 -: 3] == 3'b101) prog = delay_cfg;
            nfr++;
            gap = 0;
         end
         if (!mw_cs_o) gap++;
         if (prog > 0) prog--;
         if (prog == 0 && !rx) rdy_cyc = cyc;
         rx = (prog == 0);
      end
      p_cs = mw_cs_o; p_sck = mw_clk_o; p_tx = mw_tx_o;
   end

   function automatic logic [FRM-1:0] exp_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      return {3'b101, a, d};
   endfunction

   task automatic run_txn(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int dly, input bit exp_err, input bit poke);
      int  n = 0;
      bit  seen = 1'b0;
      int  tb0 = tx_bad;
      int  hb0 = hi_bad;
      nfr = 0; min_gap = 1000000; delay_cfg = dly;
      chk(busy_o == 1'b0, "R10 idle before start", busy_o, 0);
      addr_i = a; data_i = d; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; addr_i = AW'($urandom); data_i = DW'($urandom);
      chk(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
      chk(err_o == 1'b0, "R7 err cleared by start", err_o, 0);
      while (!seen && n < 4000) begin
         if (poke && n == 30) begin start_i = 1'b1; addr_i = ~a; data_i = ~d; end
         @(negedge clk);
         start_i = 1'b0;
         n++;
         if (done_o) seen = 1'b1;
         else chk(busy_o == 1'b1, "R10 busy held", busy_o, 1);
      end
      chk(seen, "R8 done seen", seen, 1);
      chk(busy_o == 1'b0, "R8 busy low with done", busy_o, 0);
      @(negedge clk);
      chk(done_o == 1'b0, "R8 done one cycle", done_o, 0);
      chk(nfr == 4, "R9 window count", nfr, 4);
      chk(fb[0] == 9 && fv[0][8:0] == 9'h130, "R2 unlock frame", fv[0], 32'h130);
      chk(fb[1] == FRM && fv[1][FRM-1:0] == exp_write(a, d), "R4 write frame",
          fv[1], 32'(exp_write(a, d)));
      chk(fb[2] == 0, "R6 poll without clocks", fb[2], 0);
      chk(poll_rdy == !exp_err, "R6 poll closes on ready", poll_rdy, !exp_err);
      if (!exp_err) chk(poll_lat <= DIV + 1, "R6 poll latency", poll_lat, DIV + 1);
      chk(fb[3] == 9 && fv[3][8:0] == 9'h100, "R8 lock frame", fv[3], 32'h100);
      chk(err_o == exp_err, "R7 error flag", err_o, exp_err);
      chk(min_gap >= 2 * DIV, "R3 standby gap", min_gap, 2 * DIV);
      chk(tx_bad == tb0, "R5 data steady while clock high", tx_bad, tb0);
      chk(hi_bad == hb0, "R5 clock high phase", hi_bad, hb0);
      if (poke) begin
         repeat (40) @(negedge clk);
         chk(busy_o == 1'b0 && mw_cs_o == 1'b0 && nfr == 4, "R9 no follow-on run",
             {busy_o, mw_cs_o}, 0);
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED));
      repeat (4) @(negedge clk);
      chk({mw_cs_o, mw_clk_o, mw_tx_o, busy_o, done_o, err_o} == 6'b0, "R1 in reset",
          {mw_cs_o, mw_clk_o, mw_tx_o, busy_o, done_o, err_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({mw_cs_o, mw_clk_o, mw_tx_o, busy_o, done_o, err_o} == 6'b0, "R1 after reset",
          {mw_cs_o, mw_clk_o, mw_tx_o, busy_o, done_o, err_o}, 0);

      run_txn(6'h00, 16'h0000, 0, 1'b0, 1'b0);
      run_txn(6'h3F, 16'hFFFF, 30, 1'b0, 1'b0);
      run_txn(6'h2A, 16'hA55A, 1000, 1'b1, 1'b0);
      run_txn(6'h15, 16'h1234, 10, 1'b0, 1'b1);
      run_txn(6'h01, 16'h8001, 5, 1'b0, 1'b0);
      for (int i = 0; i < 12; i++) begin
         run_txn(AW'($urandom), DW'($urandom), 2 + int'($urandom % 60), 1'b0, ($urandom % 4) == 0);
      end

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule